// File: doc/BRIEF.md
# Mode-0 Programmable Parallel Port

This block is a three-port parallel I/O peripheral that runs in basic mode only. A host reaches it over an 8-bit bus with a 16-bit I/O address, read and write strobes and a synchronous active-low reset. Two ports, A and B, are full bytes. Port C is split into an upper nibble and a lower nibble. Each of these four port groups is set to input or output by a mode word. A second control format sets or clears one port C bit without touching the rest of the port.

The block decodes its own chip select from the full address. A write lands on the rising clock edge. A read is combinational while `rd_en` is high. Each port has an input pin vector, an output latch vector and a per-bit output enable, which the chip top wires to its pads. The mode-select fields of the mode word are stored for completeness. They do not change behaviour: every port group always works as plain latched output or plain sampled input.

Top module: `ppp_mode0_port`

## Requirements
- R1: The block is selected only when `io_addr[15:12]`=4'hF, `io_addr[11]`=0 and `io_addr[10]`=1. Bits 7:0 are ignored. An unselected write changes no output, and an unselected read returns 8'h00.
- R2: `io_addr[9:8]` selects the target. 2'b00 is port A, 2'b01 is port B, 2'b10 is port C and 2'b11 is the control register.
- R3: A control write with `wdata[7]`=1 is a mode word. Bit 4 sets the direction of port A, bit 1 port B, bit 3 the upper nibble of C and bit 0 the lower nibble of C. A 1 means input and a 0 means output. The new directions take effect on the cycle after the write.
- R4: Every mode-word write clears the output latches of ports A, B and C to 8'h00.
- R5: A control write with `wdata[7]`=0 sets port C latch bit `wdata[3:1]` to `wdata[0]`. Bits 6:4 are ignored. No other latch bit and no direction changes.
- R6: Reading a port returns the pin value for bits in an input group and the latch value for bits in an output group.
- R7: Reading the control register returns 8'h00.
- R8: After reset every group is an input, all output enables are 0 and all latches are 8'h00.
- R9: Each output-enable bit is 1 exactly when its group is configured as output. The enable is uniform across the 8 bits of A and of B, and across each nibble of C.
- R10: The mode-select fields (`wdata[2]`, `wdata[6:5]` of a mode word) have no effect on directions, latches or read data.
- R11: A port data write updates that port's latch whatever its direction, and the `*_out` pins always show the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not reading the block |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable, upper and lower nibble separately |

## Verification
On every cycle the assertions check several behaviours. A mode word clears all latches and sets the enables from its direction bits. A bit command lands on the indexed port C bit and leaves everything else alone. An unselected write leaves every output stable. A control read returns zero, and the enables stay uniform within each group. Only the bench scenarios can show the rest. These are the read path that mixes pin and latch per group, the complete address decode across all upper-bit patterns, the reset state, and the fact that mode-select bits change nothing over all their combinations.

// File: rtl/ppp_pkg.sv
// Package: shared widths, target encodings and control-word field types for
// the mode-0 parallel port. Assumes an 8-bit host data bus.
package ppp_pkg;

    localparam int PORT_W  = 8;
    localparam int NIB_W   = PORT_W / 2;
    localparam int BIDX_W  = $clog2(PORT_W);

    // Target selected by the two address bits above the ignored low byte.
    typedef enum logic [1:0] {
        TGT_PA   = 2'b00,
        TGT_PB   = 2'b01,
        TGT_PC   = 2'b10,
        TGT_CTRL = 2'b11
    } ppp_tgt_e;

    // Direction of each port group: 1 = input, 0 = output.
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic ch_in;
        logic cl_in;
    } ppp_dir_t;

    // Stored (but behaviourally inert) mode-select fields.
    typedef struct packed {
        logic [1:0] grp_hi_mode;
        logic       grp_lo_mode;
    } ppp_mode_t;

    // Bit positions inside a control word.
    localparam int CW_FORMAT  = 7;
    localparam int CW_DIR_A   = 4;
    localparam int CW_DIR_CH  = 3;
    localparam int CW_MODE_LO = 2;
    localparam int CW_DIR_B   = 1;
    localparam int CW_DIR_CL  = 0;
    localparam int CW_MODE_HI = 5;
    localparam int CW_BIT_LSB = 1;
    localparam int CW_BIT_VAL = 0;

endpackage

// File: rtl/ppp_addr_decode.sv
// Module: ppp_addr_decode
// Produces the chip select and the target code from the full I/O address.
// Assumes the select bit must be 0, a contiguous field of high bits plus one
// extra bit must be 1, and the byte below the target field is ignored.
module ppp_addr_decode #(
    parameter int ADDR_W    = 16,
    parameter int SEL_BIT   = 11,
    parameter int HIGH_LSB  = 12,
    parameter int GUARD_BIT = 10,
    parameter int TGT_LSB   = 8
) (
    input  logic [ADDR_W-1:0] io_addr,
    output logic              chip_sel,
    output ppp_pkg::ppp_tgt_e target
);

    localparam int HIGH_W = ADDR_W - HIGH_LSB;

    logic high_ok;
    logic guard_ok;
    logic sel_ok;

    // Upper address field must be all ones.
    always_comb high_ok = &io_addr[ADDR_W-1:HIGH_LSB];

    // Guard bit must be one, select bit must be zero.
    always_comb begin
        guard_ok = io_addr[GUARD_BIT];
        sel_ok   = ~io_addr[SEL_BIT];
    end

    // Combined chip select.
    always_comb chip_sel = high_ok & guard_ok & sel_ok;

    // Target code from the two bits above the ignored byte.
    always_comb target = ppp_pkg::ppp_tgt_e'(io_addr[TGT_LSB +: 2]);

    // Width guard kept explicit so a bad parameter set shows up at elaboration.
    if (HIGH_W < 1) begin : g_bad_high
        initial $error("address high field is empty");
    end

endmodule

// File: rtl/ppp_ctrl_reg.sv
// Module: ppp_ctrl_reg
// Holds port directions and mode fields. Splits a control write into a mode
// word (format bit set) or a port C bit command (format bit clear).
// Assumes wr_ctrl is already qualified by chip select and target.
module ppp_ctrl_reg #(
    parameter int DATA_W = ppp_pkg::PORT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_ctrl,
    input  logic [DATA_W-1:0]           wdata,
    output ppp_pkg::ppp_dir_t           dir,
    output ppp_pkg::ppp_mode_t          mode,
    output logic                        mode_wr,
    output logic                        bsr_wr,
    output logic [ppp_pkg::BIDX_W-1:0]  bsr_idx,
    output logic                        bsr_val
);

    import ppp_pkg::*;

    ppp_dir_t  dir_q;
    ppp_mode_t mode_q;
    ppp_dir_t  dir_d;
    ppp_mode_t mode_d;

    // Classify the control write by its format bit.
    always_comb begin
        mode_wr = wr_ctrl &  wdata[CW_FORMAT];
        bsr_wr  = wr_ctrl & ~wdata[CW_FORMAT];
    end

    // Extract the bit command fields; upper unused bits are dropped.
    always_comb begin
        bsr_idx = wdata[CW_BIT_LSB +: BIDX_W];
        bsr_val = wdata[CW_BIT_VAL];
    end

    // Decode direction and mode fields of a candidate mode word.
    always_comb begin
        dir_d.a_in         = wdata[CW_DIR_A];
        dir_d.b_in         = wdata[CW_DIR_B];
        dir_d.ch_in        = wdata[CW_DIR_CH];
        dir_d.cl_in        = wdata[CW_DIR_CL];
        mode_d.grp_hi_mode = wdata[CW_MODE_HI +: 2];
        mode_d.grp_lo_mode = wdata[CW_MODE_LO];
    end

    // Register directions; reset makes every group an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '{a_in: 1'b1, b_in: 1'b1, ch_in: 1'b1, cl_in: 1'b1};
        end else if (mode_wr) begin
            dir_q <= dir_d;
        end
    end

    // Register mode fields; they are kept but drive nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_d;
        end
    end

    // Drive outputs from state.
    always_comb begin
        dir  = dir_q;
        mode = mode_q;
    end

endmodule

// File: rtl/ppp_out_latch.sv
// Module: ppp_out_latch
// One port's output latch. Priority: clear (mode word) over full write over
// single-bit command. HAS_BITCMD selects whether the bit command exists.
// Assumes the enables are already qualified by chip select and target.
module ppp_out_latch #(
    parameter int W          = ppp_pkg::PORT_W,
    parameter bit HAS_BITCMD = 1'b0,
    localparam int IDX_W     = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);

    logic [W-1:0] q_r;
    logic [W-1:0] bit_hit;
    logic [W-1:0] bit_next;

    // Per-bit decode of the single-bit command, present only if enabled.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (HAS_BITCMD) begin : g_cmd
            always_comb begin
                bit_hit[i]  = bit_wr && (bit_idx == IDX_W'(i));
                bit_next[i] = bit_hit[i] ? bit_val : q_r[i];
            end
        end else begin : g_nocmd
            always_comb begin
                bit_hit[i]  = 1'b0;
                bit_next[i] = q_r[i];
            end
        end
    end

    // Latch update with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (clr) begin
            q_r <= '0;
        end else if (wr) begin
            q_r <= wdata;
        end else if (|bit_hit) begin
            q_r <= bit_next;
        end
    end

    // Present the latch.
    always_comb q = q_r;

endmodule

// File: rtl/ppp_read_mux.sv
// Module: ppp_read_mux
// Builds host read data: per-group choice of pin or latch, zero for the
// control target and when the block is not being read.
module ppp_read_mux #(
    parameter int W = ppp_pkg::PORT_W
) (
    input  logic               rd_sel,
    input  ppp_pkg::ppp_tgt_e  target,
    input  ppp_pkg::ppp_dir_t  dir,
    input  logic [W-1:0]       pa_in,
    input  logic [W-1:0]       pa_lat,
    input  logic [W-1:0]       pb_in,
    input  logic [W-1:0]       pb_lat,
    input  logic [W-1:0]       pc_in,
    input  logic [W-1:0]       pc_lat,
    output logic [W-1:0]       rdata
);

    import ppp_pkg::*;

    localparam int H = W / 2;

    logic [W-1:0] a_mask;
    logic [W-1:0] b_mask;
    logic [W-1:0] c_mask;
    logic [W-1:0] a_view;
    logic [W-1:0] b_view;
    logic [W-1:0] c_view;

    // Input masks: a set bit takes the pin, a clear bit takes the latch.
    always_comb begin
        a_mask = {W{dir.a_in}};
        b_mask = {W{dir.b_in}};
        c_mask = {{(W-H){dir.ch_in}}, {H{dir.cl_in}}};
    end

    // Merge pin and latch per port.
    always_comb begin
        a_view = (pa_in & a_mask) | (pa_lat & ~a_mask);
        b_view = (pb_in & b_mask) | (pb_lat & ~b_mask);
        c_view = (pc_in & c_mask) | (pc_lat & ~c_mask);
    end

    // Select by target; control and idle return zero.
    always_comb begin
        rdata = '0;
        if (rd_sel) begin
            unique case (target)
                TGT_PA:   rdata = a_view;
                TGT_PB:   rdata = b_view;
                TGT_PC:   rdata = c_view;
                TGT_CTRL: rdata = '0;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ppp_mode0_port.sv
// Module: ppp_mode0_port (top)
// Three-port basic-mode parallel I/O block with full-address chip select,
// mode words that set group directions and clear all latches, and single-bit
// commands on port C. Writes act on the clock edge; reads are combinational.
// Assumes a single clock domain; pin inputs are already synchronised.
module ppp_mode0_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = ppp_pkg::PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);

    import ppp_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = $clog2(DATA_W);

    logic               chip_sel;
    ppp_tgt_e           target;
    logic               wr_sel;
    logic               rd_sel;
    logic               wr_a;
    logic               wr_b;
    logic               wr_c;
    logic               wr_ctrl;
    ppp_dir_t           dir;
    ppp_mode_t          mode;
    logic               mode_wr;
    logic               bsr_wr;
    logic [IDX_W-1:0]   bsr_idx;
    logic               bsr_val;
    logic [DATA_W-1:0]  a_lat;
    logic [DATA_W-1:0]  b_lat;
    logic [DATA_W-1:0]  c_lat;

    ppp_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .io_addr  (io_addr),
        .chip_sel (chip_sel),
        .target   (target)
    );

    // Qualify strobes with chip select.
    always_comb begin
        wr_sel = wr_en & chip_sel;
        rd_sel = rd_en & chip_sel;
    end

    // Per-target write enables.
    always_comb begin
        wr_a    = wr_sel && (target == TGT_PA);
        wr_b    = wr_sel && (target == TGT_PB);
        wr_c    = wr_sel && (target == TGT_PC);
        wr_ctrl = wr_sel && (target == TGT_CTRL);
    end

    ppp_ctrl_reg #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata),
        .dir     (dir),
        .mode    (mode),
        .mode_wr (mode_wr),
        .bsr_wr  (bsr_wr),
        .bsr_idx (bsr_idx),
        .bsr_val (bsr_val)
    );

    ppp_out_latch #(
        .W          (DATA_W),
        .HAS_BITCMD (1'b0)
    ) u_lat_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_wr),
        .wr      (wr_a),
        .wdata   (wdata),
        .bit_wr  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .q       (a_lat)
    );

    ppp_out_latch #(
        .W          (DATA_W),
        .HAS_BITCMD (1'b0)
    ) u_lat_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_wr),
        .wr      (wr_b),
        .wdata   (wdata),
        .bit_wr  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .q       (b_lat)
    );

    ppp_out_latch #(
        .W          (DATA_W),
        .HAS_BITCMD (1'b1)
    ) u_lat_c (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_wr),
        .wr      (wr_c),
        .wdata   (wdata),
        .bit_wr  (bsr_wr),
        .bit_idx (bsr_idx),
        .bit_val (bsr_val),
        .q       (c_lat)
    );

    ppp_read_mux #(
        .W (DATA_W)
    ) u_rmux (
        .rd_sel (rd_sel),
        .target (target),
        .dir    (dir),
        .pa_in  (pa_in),
        .pa_lat (a_lat),
        .pb_in  (pb_in),
        .pb_lat (b_lat),
        .pc_in  (pc_in),
        .pc_lat (c_lat),
        .rdata  (rdata)
    );

    // Output pins always show the latches.
    always_comb begin
        pa_out = a_lat;
        pb_out = b_lat;
        pc_out = c_lat;
    end

    // Output enables follow group direction.
    always_comb begin
        pa_oe = {DATA_W{~dir.a_in}};
        pb_oe = {DATA_W{~dir.b_in}};
        pc_oe = {{(DATA_W-HALF_W){~dir.ch_in}}, {HALF_W{~dir.cl_in}}};
    end

    // Mode fields are retained state only; fold them into an unused net.
    logic mode_unused;
    always_comb mode_unused = ^{mode.grp_hi_mode, mode.grp_lo_mode};

endmodule

// File: rtl/ppp_mode0_port_chk.sv
// Module: ppp_mode0_port_chk
// Assertion checker bound to the top. Re-derives the chip select from the
// address pins independently of the design's decoder.
module ppp_mode0_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic [7:0]  pa_out,
    input logic [7:0]  pa_oe,
    input logic [7:0]  pb_out,
    input logic [7:0]  pb_oe,
    input logic [7:0]  pc_out,
    input logic [7:0]  pc_oe
);

    logic hit;
    logic ctl_wr;

    // Independent address match and control-write detection.
    always_comb begin
        hit    = (io_addr[15:12] == 4'hF) && !io_addr[11] && io_addr[10];
        ctl_wr = wr_en && hit && (io_addr[9:8] == 2'b11);
    end

    // R4
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R3
    mode_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=>
            (pa_oe == {8{~$past(wdata[4])}} && pb_oe == {8{~$past(wdata[1])}} &&
             pc_oe == {{4{~$past(wdata[3])}}, {4{~$past(wdata[0])}}}));

    // R5
    bsr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=> (pc_out[$past(wdata[3:1])] == $past(wdata[0])));

    // R5
    bsr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=>
            ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) &&
             $stable(pb_oe) && $stable(pc_oe)));

    // R1
    unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=>
            ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
             $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    // R7
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit && io_addr[9:8] == 2'b11) |-> (rdata == 8'h00));

    // R9
    oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) &&
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

endmodule

bind ppp_mode0_port ppp_mode0_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out),
    .pb_oe   (pb_oe),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe)
);

// File: tb/tb_ppp_mode0_port.sv
// Bench for ppp_mode0_port: sweeps all direction and mode-field combinations,
// every port C bit command, and every upper-address pattern.
module tb_ppp_mode0_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [7:0]  pa_in = 8'h00;
    logic [7:0]  pa_out;
    logic [7:0]  pa_oe;
    logic [7:0]  pb_in = 8'h00;
    logic [7:0]  pb_out;
    logic [7:0]  pb_oe;
    logic [7:0]  pc_in = 8'h00;
    logic [7:0]  pc_out;
    logic [7:0]  pc_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [15:0] A_PA   = 16'hF400;
    localparam logic [15:0] A_PB   = 16'hF500;
    localparam logic [15:0] A_PC   = 16'hF600;
    localparam logic [15:0] A_CTRL = 16'hF700;

    always #2.5 clk = ~clk;

    ppp_mode0_port dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_addr (io_addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .pa_in   (pa_in),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_in   (pb_in),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pc_in   (pc_in),
        .pc_out  (pc_out),
        .pc_oe   (pc_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write at a falling edge, commit at the rising edge, return at the next falling edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        wdata   = d;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        rd_en   = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] merge(input logic [7:0] pin, input logic [7:0] lat,
                                         input logic [7:0] in_mask);
        return (pin & in_mask) | (lat & ~in_mask);
    endfunction

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_c;
        pa_in = 8'h3C;
        pb_in = 8'hC3;
        pc_in = 8'h96;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        chk("R8 oe", {8'h0, pa_oe, pb_oe, pc_oe}, 32'h0);
        chk("R8 latches", {8'h0, pa_out, pb_out, pc_out}, 32'h0);
        rd(A_PA, r); chk("R8 R6 read A pin", {24'h0, r}, {24'h0, 8'h3C});
        rd(A_PC, r); chk("R8 R6 read C pin", {24'h0, r}, {24'h0, 8'h96});
        // R7: control read
        rd(A_CTRL, r); chk("R7 ctrl read", {24'h0, r}, 32'h0);
        // R11: latch written while input
        wr(A_PB, 8'h5E); chk("R11 B latch while input", {24'h0, pb_out}, {24'h0, 8'h5E});

        // R3 R4 R6 R9 R10 R2: sweep directions x mode fields
        for (int d = 0; d < 16; d++) begin
            for (int m = 0; m < 8; m++) begin
                logic [3:0] dv;
                logic [2:0] mv;
                logic [7:0] mw;
                logic [7:0] am;
                logic [7:0] bm;
                logic [7:0] cm;
                logic [7:0] la;
                logic [7:0] lb;
                logic [7:0] lc;
                dv = 4'(d);
                mv = 3'(m);
                mw = {1'b1, mv[2:1], dv[3], dv[2], mv[0], dv[1], dv[0]};
                wr(A_PA, 8'hA5); wr(A_PB, 8'h5A); wr(A_PC, 8'h3C);
                wr(A_CTRL, mw);
                chk("R4 clear", {8'h0, pa_out, pb_out, pc_out}, 32'h0);
                am = {8{dv[3]}};
                bm = {8{dv[1]}};
                cm = {{4{dv[2]}}, {4{dv[0]}}};
                chk("R3 R9 R10 oe", {8'h0, pa_oe, pb_oe, pc_oe}, {8'h0, ~am, ~bm, ~cm});
                pa_in = 8'(d * 17 + m);
                pb_in = 8'(~(d * 5 + m * 29));
                pc_in = 8'(d * 11 ^ m * 73);
                la = 8'(d * 16 + m * 3 + 1);
                lb = 8'(d * 7 + m * 31 + 2);
                lc = 8'(d * 13 + m * 19 + 3);
                wr(A_PA, la); wr(A_PB, lb); wr(A_PC, lc);
                chk("R11 R2 outs", {8'h0, pa_out, pb_out, pc_out}, {8'h0, la, lb, lc});
                rd(A_PA, r); chk("R6 R2 read A", {24'h0, r}, {24'h0, merge(pa_in, la, am)});
                rd(A_PB, r); chk("R6 R2 read B", {24'h0, r}, {24'h0, merge(pb_in, lb, bm)});
                rd(A_PC, r); chk("R6 R2 read C", {24'h0, r}, {24'h0, merge(pc_in, lc, cm)});
            end
        end

        // R5: every bit index, value and ignored-field pattern
        wr(A_CTRL, 8'h80);
        wr(A_PA, 8'h77); wr(A_PB, 8'h44);
        exp_c = 8'h00;
        for (int i = 0; i < 8; i++) begin
            for (int v = 0; v < 2; v++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [7:0] cmd;
                    cmd = {1'b0, 3'(j), 3'(i), 1'(v)};
                    wr(A_CTRL, cmd);
                    exp_c[i] = 1'(v);
                    chk("R5 bit cmd", {8'h0, pc_out, pa_out, pb_out}, {8'h0, exp_c, 8'h77, 8'h44});
                    chk("R5 dir kept", {8'h0, pa_oe, pb_oe, pc_oe}, 32'h00FFFFFF);
                end
            end
        end

        // R1: sweep all upper-address patterns, low byte varied
        wr(A_CTRL, 8'h80);
        begin
            logic [7:0] exp_a;
            exp_a = 8'h00;
            for (int h = 0; h < 64; h++) begin
                logic [15:0] a;
                logic        sel;
                a = {6'(h), 2'b00, 8'(h * 37 + 5)};
                sel = (6'(h) == 6'b111101);
                wr(a, 8'(h + 1));
                if (sel) exp_a = 8'(h + 1);
                chk("R1 write decode", {24'h0, pa_out}, {24'h0, exp_a});
                rd(a, r);
                chk("R1 read decode", {24'h0, r}, sel ? {24'h0, exp_a} : 32'h0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule